// File: doc/BRIEF.md
# Fault Supervisor Sequencer

This block sequences power-up and protection for an off-line switching controller. Its inputs are already-digitised comparator flags: supply above the turn-on level, below the undervoltage level, below the deep-reset level, and above the overvoltage level. It also takes feedback overload, over-temperature, shorted-winding current sense, and two levels on the external blanking pin (too low, and fully charged). A timebase strobe paces all timing. The block drives the startup current source enable, the switching enable, an 8-bit soft-start code and the charge enable for the external blanking capacitor. It also reports the current state on a 3-bit code.

Faults fall into two classes. Auto-restart faults are undervoltage, and overload that persists through both blanking phases. They stop switching and let the supply drain to the undervoltage level. The supply is then recharged to the turn-on level and a fresh soft start is attempted. Lock faults are over-temperature, shorted current sense, a grounded blanking pin, and overvoltage together with overload. They stop switching until the supply falls below the deep-reset level. While locked, only the undervoltage hysteresis keeps toggling the startup source.

All pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The soft-start window is 256 × `SS_STEP_TICKS` timebase ticks. The fixed blanking window is `BLANK_TICKS` ticks.

Top module: `fault_seq`

## Requirements
- R1: While reset is low and right after it, the state code is 0 (off). In this state the startup source is enabled, and switching, capacitor charge and the soft-start code are all 0.
- R2: In state 0 or state 1 (recharge), the startup source is on and switching is off. A high turn-on flag moves the block to state 2 (soft start) at the next clock. There the startup source is off and switching is on.
- R3: In state 2 the code starts at 0 and rises by 1 after every `SS_STEP_TICKS` ticks. It holds while the tick strobe is low. After 256 steps the block enters state 3 (run) and the code stays at 255. Feedback overload has no effect during state 2.
- R4: In states 2, 3 or 4, any one of these moves the block to state 6 (locked) at the next clock: over-temperature, shorted sense, a low blanking pin, or overvoltage together with overload. Overvoltage alone has no effect.
- R5: A lock fault wins over undervoltage, over overload and over blanking expiry that occur in the same cycle.
- R6: Overload in state 3 moves the block to state 4 (blanking). For the first `BLANK_TICKS` ticks the charge enable stays 0 and a full blanking pin is ignored. After that the charge enable is 1.
- R7: While the charge enable is 1, a full blanking pin moves the block to state 5 (auto-restart) at the next clock. Switching and charge are then off.
- R8: If overload clears in state 4, the block returns to state 3 at the next clock with the charge enable 0. The next overload starts a full fixed window again.
- R9: Undervoltage in states 2, 3 or 4 with no lock fault moves the block to state 1 at the next clock.
- R10: In state 5 both the startup source and switching stay off until undervoltage, which moves the block to state 1. From state 1, the turn-on flag starts a new soft start from code 0.
- R11: In state 6 switching stays off. The startup source turns on at the clock after undervoltage and off at the clock after the turn-on flag.
- R12: State 6 is left only when the deep-reset flag is seen, going to state 0. The turn-on flag alone does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| vcc_on_i | input | 1 | Supply at or above the turn-on level |
| vcc_uv_i | input | 1 | Supply below the undervoltage level |
| vcc_deep_i | input | 1 | Supply below the deep-reset level |
| vcc_ov_i | input | 1 | Supply above the overvoltage level |
| fb_ovl_i | input | 1 | Feedback above the overload level |
| temp_hot_i | input | 1 | Over-temperature |
| cs_short_i | input | 1 | Current sense above the shorted-winding level |
| blk_low_i | input | 1 | Blanking pin pulled below the lock level |
| blk_full_i | input | 1 | Blanking pin charged to its end level |
| src_en_o | output | 1 | Startup current source enable |
| pwm_en_o | output | 1 | Switching enable |
| ramp_o | output | RAMP_W | Soft-start code |
| blk_chg_o | output | 1 | Blanking capacitor charge enable |
| state_o | output | 3 | State code (0 off, 1 recharge, 2 soft start, 3 run, 4 blanking, 5 auto-restart, 6 locked) |

## Verification
Every output is decoded from registered state, so a wrong state register shows on the state code and the enables one clock after the input that caused it. A stray lock or a missed lock shows at once as switching held off, or not cut off. A soft-start divider that slips shows as a code that is off by one at the next sampled step. The run entry then moves by `SS_STEP_TICKS` cycles. A blanking counter that is short or does not restart shows as the charge enable rising a cycle early, or immediately after a released overload.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_START = 3'd1,
    ST_SOFT  = 3'd2,
    ST_RUN   = 3'd3,
    ST_BLANK = 3'd4,
    ST_RETRY = 3'd5,
    ST_LOCK  = 3'd6
  } fs_state_e;

  function automatic logic fs_switching(input fs_state_e s);
    return (s == ST_SOFT) || (s == ST_RUN) || (s == ST_BLANK);
  endfunction
endpackage

// File: rtl/fs_fault_class.sv
module fs_fault_class (
  input  logic vcc_ov_i,
  input  logic fb_ovl_i,
  input  logic temp_hot_i,
  input  logic cs_short_i,
  input  logic blk_low_i,
  input  logic vcc_uv_i,
  output logic lock_o,
  output logic uv_o,
  output logic ovl_o
);
  localparam int N_LOCK = 4;
  logic [N_LOCK-1:0] lock_cause;

  // overvoltage only counts when feedback also sits in overload
  assign lock_cause = {vcc_ov_i & fb_ovl_i, temp_hot_i, cs_short_i, blk_low_i};
  assign lock_o     = |lock_cause;
  assign uv_o       = vcc_uv_i & ~lock_o;
  assign ovl_o      = fb_ovl_i & ~lock_o & ~vcc_uv_i;
endmodule

// File: rtl/fs_soft_ramp.sv
module fs_soft_ramp #(
  parameter int RAMP_W     = 8,
  parameter int STEP_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  output logic [RAMP_W-1:0] code_o,
  output logic              done_o
);
  localparam logic [RAMP_W-1:0] CODE_MAX = {RAMP_W{1'b1}};

  logic              step_end;
  logic [RAMP_W-1:0] code_q;

  generate
    if (STEP_TICKS <= 1) begin : g_nodiv
      assign step_end = run & tick;
    end else begin : g_div
      localparam int DIV_W = $clog2(STEP_TICKS);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_TICKS - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           div_q <= '0;
        else if (clr)         div_q <= '0;
        else if (run && tick) div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end

      assign step_end = run & tick & (div_q == DIV_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            code_q <= '0;
    else if (clr)                          code_q <= '0;
    else if (step_end && code_q != CODE_MAX) code_q <= code_q + 1'b1;
  end

  assign code_o = code_q;
  assign done_o = step_end & (code_q == CODE_MAX);
endmodule

// File: rtl/fs_blank_timer.sv
module fs_blank_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_END = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!arm)                     cnt_q <= '0;
    else if (tick && cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CNT_END);
endmodule

// File: rtl/fault_seq.sv
module fault_seq
  import fault_seq_pkg::*;
#(
  parameter int RAMP_W        = 8,
  parameter int SS_STEP_TICKS = 8,
  parameter int BLANK_TICKS   = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              vcc_on_i,
  input  logic              vcc_uv_i,
  input  logic              vcc_deep_i,
  input  logic              vcc_ov_i,
  input  logic              fb_ovl_i,
  input  logic              temp_hot_i,
  input  logic              cs_short_i,
  input  logic              blk_low_i,
  input  logic              blk_full_i,
  output logic              src_en_o,
  output logic              pwm_en_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              blk_chg_o,
  output logic [2:0]        state_o
);
  fs_state_e st_q, st_d;
  logic      lock_req, uv_req, ovl_req;
  logic      ramp_done, blank_expired;
  logic      uvlo_src_q;
  logic      switching;

  fs_fault_class u_class (
    .vcc_ov_i   (vcc_ov_i),
    .fb_ovl_i   (fb_ovl_i),
    .temp_hot_i (temp_hot_i),
    .cs_short_i (cs_short_i),
    .blk_low_i  (blk_low_i),
    .vcc_uv_i   (vcc_uv_i),
    .lock_o     (lock_req),
    .uv_o       (uv_req),
    .ovl_o      (ovl_req)
  );

  assign switching = fs_switching(st_q);

  fs_soft_ramp #(
    .RAMP_W     (RAMP_W),
    .STEP_TICKS (SS_STEP_TICKS)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~switching),
    .run    (st_q == ST_SOFT),
    .tick   (tick_i),
    .code_o (ramp_o),
    .done_o (ramp_done)
  );

  fs_blank_timer #(
    .LIMIT (BLANK_TICKS)
  ) u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (st_q == ST_BLANK),
    .tick      (tick_i),
    .expired_o (blank_expired)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF, ST_START: if (vcc_on_i) st_d = ST_SOFT;
      ST_SOFT: begin
        if (lock_req)       st_d = ST_LOCK;
        else if (uv_req)    st_d = ST_START;
        else if (ramp_done) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (lock_req)     st_d = ST_LOCK;
        else if (uv_req)  st_d = ST_START;
        else if (ovl_req) st_d = ST_BLANK;
      end
      ST_BLANK: begin
        if (lock_req)                        st_d = ST_LOCK;
        else if (uv_req)                     st_d = ST_START;
        else if (!ovl_req)                   st_d = ST_RUN;
        else if (blank_expired && blk_full_i) st_d = ST_RETRY;
      end
      ST_RETRY: if (vcc_uv_i)   st_d = ST_START;
      ST_LOCK:  if (vcc_deep_i) st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  // undervoltage hysteresis kept alive while locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               uvlo_src_q <= 1'b0;
    else if (st_q != ST_LOCK) uvlo_src_q <= 1'b0;
    else if (vcc_uv_i)        uvlo_src_q <= 1'b1;
    else if (vcc_on_i)        uvlo_src_q <= 1'b0;
  end

  assign src_en_o  = (st_q == ST_OFF) || (st_q == ST_START) ||
                     ((st_q == ST_LOCK) && uvlo_src_q);
  assign pwm_en_o  = switching;
  assign blk_chg_o = (st_q == ST_BLANK) && blank_expired;
  assign state_o   = st_q;
endmodule

// File: rtl/fault_seq_chk.sv
module fault_seq_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vcc_uv_i,
  input logic              vcc_deep_i,
  input logic              vcc_ov_i,
  input logic              fb_ovl_i,
  input logic              temp_hot_i,
  input logic              cs_short_i,
  input logic              blk_low_i,
  input logic              src_en_o,
  input logic              pwm_en_o,
  input logic [RAMP_W-1:0] ramp_o,
  input logic              blk_chg_o,
  input logic [2:0]        state_o
);
  logic lock_in;
  assign lock_in = temp_hot_i | cs_short_i | blk_low_i | (vcc_ov_i & fb_ovl_i);

  AST_SRC_PWM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_en_o && pwm_en_o)); // R2

  AST_RAMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |=> (state_o != 3'd2 || ramp_o >= $past(ramp_o))); // R3

  AST_SOFT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 3'd2) |=> (state_o != 3'd2 || ramp_o == '0)); // R10

  AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en_o && lock_in) |=> (state_o == 3'd6)); // R5

  AST_RELEASE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_chg_o && !fb_ovl_i && !lock_in && !vcc_uv_i) |=> (state_o == 3'd3 && !blk_chg_o)); // R8

  AST_UV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en_o && !lock_in && vcc_uv_i) |=> (state_o == 3'd1)); // R9

  AST_LOCK_NO_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |-> !pwm_en_o); // R11

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6 && !vcc_deep_i) |=> (state_o == 3'd6)); // R12
endmodule

bind fault_seq fault_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vcc_uv_i   (vcc_uv_i),
  .vcc_deep_i (vcc_deep_i),
  .vcc_ov_i   (vcc_ov_i),
  .fb_ovl_i   (fb_ovl_i),
  .temp_hot_i (temp_hot_i),
  .cs_short_i (cs_short_i),
  .blk_low_i  (blk_low_i),
  .src_en_o   (src_en_o),
  .pwm_en_o   (pwm_en_o),
  .ramp_o     (ramp_o),
  .blk_chg_o  (blk_chg_o),
  .state_o    (state_o)
);

// File: tb/fault_seq_bench.sv
module fault_seq_bench;
  localparam int STEP  = 2;
  localparam int BLANK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic vcc_on_i = 1'b0, vcc_uv_i = 1'b0, vcc_deep_i = 1'b0, vcc_ov_i = 1'b0;
  logic fb_ovl_i = 1'b0, temp_hot_i = 1'b0, cs_short_i = 1'b0;
  logic blk_low_i = 1'b0, blk_full_i = 1'b0;
  logic src_en_o, pwm_en_o, blk_chg_o;
  logic [7:0] ramp_o;
  logic [2:0] state_o;

  always #2 clk = ~clk;

  fault_seq #(.RAMP_W(8), .SS_STEP_TICKS(STEP), .BLANK_TICKS(BLANK)) u_fault_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .vcc_on_i(vcc_on_i), .vcc_uv_i(vcc_uv_i), .vcc_deep_i(vcc_deep_i), .vcc_ov_i(vcc_ov_i),
    .fb_ovl_i(fb_ovl_i), .temp_hot_i(temp_hot_i), .cs_short_i(cs_short_i),
    .blk_low_i(blk_low_i), .blk_full_i(blk_full_i),
    .src_en_o(src_en_o), .pwm_en_o(pwm_en_o), .ramp_o(ramp_o),
    .blk_chg_o(blk_chg_o), .state_o(state_o)
  );

  typedef struct {
    string      tag;
    logic [2:0] st;
    logic       src;
    logic       pwm;
    logic       chg;
    int         ramp;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  task automatic expect_out(input string tag, input logic [2:0] st, input logic src,
                            input logic pwm, input logic chg, input int ramp);
    exp_t it;
    it.tag = tag; it.st = st; it.src = src; it.pwm = pwm; it.chg = chg; it.ramp = ramp;
    exp_q.push_back(it);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_checks++;
        if (state_o !== it.st || src_en_o !== it.src || pwm_en_o !== it.pwm ||
            blk_chg_o !== it.chg || (it.ramp >= 0 && int'(ramp_o) != it.ramp)) begin
          n_fail++;
          $display("FAIL %s: got state=%0d src=%0b pwm=%0b chg=%0b ramp=%0d, expected state=%0d src=%0b pwm=%0b chg=%0b ramp=%0d",
                   it.tag, state_o, src_en_o, pwm_en_o, blk_chg_o, ramp_o,
                   it.st, it.src, it.pwm, it.chg, it.ramp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got still running, expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_out("R1 in reset", 3'd0, 1, 0, 0, 0);
    rst_n = 1'b1;
    cyc(2);
    expect_out("R1 after reset", 3'd0, 1, 0, 0, 0);

    vcc_on_i = 1; cyc(1);
    expect_out("R2 turn-on to soft start", 3'd2, 0, 1, 0, 0);
    vcc_on_i = 0; fb_ovl_i = 1;
    cyc(10);
    expect_out("R3 ramp step, overload ignored", 3'd2, 0, 1, 0, 5);
    tick_i = 0; cyc(20);
    expect_out("R3 ramp holds without tick", 3'd2, 0, 1, 0, 5);
    tick_i = 1; fb_ovl_i = 0;
    cyc(500);
    expect_out("R3 ramp at top", 3'd2, 0, 1, 0, 255);
    cyc(2);
    expect_out("R3 run after window", 3'd3, 0, 1, 0, 255);

    fb_ovl_i = 1; blk_full_i = 1; cyc(1);
    expect_out("R6 overload enters blanking", 3'd4, 0, 1, 0, 255);
    cyc(9);
    expect_out("R6 fixed window, full pin ignored", 3'd4, 0, 1, 0, 255);
    blk_full_i = 0; cyc(1);
    expect_out("R6 charge phase", 3'd4, 0, 1, 1, 255);
    fb_ovl_i = 0; cyc(1);
    expect_out("R8 overload released", 3'd3, 0, 1, 0, 255);
    fb_ovl_i = 1; cyc(1);
    cyc(9);
    expect_out("R8 timer restarted", 3'd4, 0, 1, 0, 255);
    cyc(1);
    expect_out("R6 charge phase again", 3'd4, 0, 1, 1, 255);
    blk_full_i = 1; cyc(1);
    expect_out("R7 auto-restart", 3'd5, 0, 0, 0, -1);
    fb_ovl_i = 0; blk_full_i = 0; cyc(5);
    expect_out("R10 wait for drain", 3'd5, 0, 0, 0, -1);
    vcc_uv_i = 1; cyc(1);
    expect_out("R10 recharge", 3'd1, 1, 0, 0, 0);
    vcc_uv_i = 0; vcc_on_i = 1; cyc(1);
    expect_out("R10 new soft start", 3'd2, 0, 1, 0, 0);
    vcc_on_i = 0;

    vcc_uv_i = 1; cyc(1);
    expect_out("R9 undervoltage in soft start", 3'd1, 1, 0, 0, 0);
    vcc_uv_i = 0; vcc_on_i = 1; cyc(1);
    vcc_on_i = 0;
    vcc_ov_i = 1; cyc(3);
    expect_out("R4 overvoltage alone ignored", 3'd2, 0, 1, 0, -1);
    fb_ovl_i = 1; cyc(1);
    expect_out("R4 overvoltage with overload locks", 3'd6, 0, 0, 0, -1);
    vcc_ov_i = 0; fb_ovl_i = 0;

    vcc_on_i = 1; cyc(2);
    expect_out("R12 turn-on does not clear", 3'd6, 0, 0, 0, -1);
    vcc_on_i = 0; vcc_uv_i = 1; cyc(1);
    expect_out("R11 source on at undervoltage", 3'd6, 1, 0, 0, -1);
    vcc_uv_i = 0; cyc(2);
    expect_out("R11 source held", 3'd6, 1, 0, 0, -1);
    vcc_on_i = 1; cyc(1);
    expect_out("R11 source off at turn-on", 3'd6, 0, 0, 0, -1);
    vcc_on_i = 0; vcc_deep_i = 1; vcc_uv_i = 1; cyc(1);
    expect_out("R12 deep reset clears", 3'd0, 1, 0, 0, 0);
    vcc_deep_i = 0; vcc_uv_i = 0;

    vcc_on_i = 1; cyc(1);
    vcc_on_i = 0; temp_hot_i = 1; vcc_uv_i = 1; cyc(1);
    expect_out("R5 lock beats undervoltage", 3'd6, 0, 0, 0, -1);
    temp_hot_i = 0; vcc_uv_i = 0; vcc_deep_i = 1; cyc(1);
    vcc_deep_i = 0;
    vcc_on_i = 1; cyc(1);
    vcc_on_i = 0; cyc(512);
    expect_out("R3 full window again", 3'd3, 0, 1, 0, 255);
    fb_ovl_i = 1; cs_short_i = 1; cyc(1);
    expect_out("R5 lock beats overload", 3'd6, 0, 0, 0, -1);
    fb_ovl_i = 0; cs_short_i = 0; vcc_deep_i = 1; cyc(1);
    vcc_deep_i = 0;
    vcc_on_i = 1; cyc(1);
    vcc_on_i = 0; blk_low_i = 1; cyc(1);
    expect_out("R4 grounded blanking pin locks", 3'd6, 0, 0, 0, -1);
    blk_low_i = 0;

    cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule